// File: doc/BRIEF.md
# Clustered Hashed Page-Table Walker

This block services a translation miss by searching a hashed page table held in memory. Each table entry covers a cluster of four consecutive virtual pages under one tag and one link to the next entry. A virtual page number arrives on the request port. The walker folds the cluster tag into a bucket index and reads that bucket's head pointer from the bucket array, whose base address is a configuration input. It then follows the linked entries, comparing each stored tag, until it finds a match or reaches a null link. It answers with a physical page number or a fault.

Memory is reached through a port that carries one 64-bit word read per request, with a valid/ready request handshake and a response of variable latency. A parameter selects one of two entry layouts. In complete mode, an entry holds four independent frame numbers, one for each page of the cluster. In partial mode, an entry holds one base frame together with a four-bit residency map packed into the low bits of the same word.

Top module: `cpt_walker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: The first memory read of a walk is at cfg_base + 8*H. H is IDX_W bits wide. Bit b of H is the XOR of every bit vpn[i], for i from 2 to VPN_W-1, with (i-2) mod IDX_W equal to b.
- R3: A bucket word equal to zero ends the walk after that single read, with a fault response.
- R4: An entry's word at offset 0 is its tag. Bits [VPN_W-1:0] of this word are compared with the request's page number with bits 1:0 cleared, and higher bits are ignored. On a mismatch, the next read is the link word at offset 40 (complete mode) or offset 16 (partial mode). A nonzero link is the address of the next entry.
- R5: A link word equal to zero ends the walk with a fault. Every fault response carries rsp_ppn equal to 0.
- R6: Complete mode (PARTIAL=0): after a tag match, the walker reads the word at entry + 8*(1+s), where s = vpn[1:0]. It returns bits [PPN_W-1:0] of that word without a fault, and higher bits are ignored.
- R7: Partial mode (PARTIAL=1): after a tag match, the walker reads the word at entry + 8. Bits [3:0] of this word are the residency map, bits [11:4] are ignored, and bits [12+PPN_W-1:12] are the base frame. If map bit s is set, the response is base + s without a fault; if it is clear, the response is a fault.
- R8: The walker keeps at most one memory read outstanding. While mem_req_valid is high and mem_req_ready is low, the request and its address stay unchanged.
- R9: After a request is accepted, req_ready stays low until the response. rsp_valid is a single-cycle pulse.
- R10: Every memory read address is a multiple of 8 when cfg_base and all stored pointers are multiples of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 64 | Byte address of bucket array |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | No valid mapping found |
| rsp_ppn | output | PPN_W | Translated physical page number |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Byte address of word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data word |

## Verification
The assertions assume that the memory returns exactly one data beat per accepted read and never returns data unprompted. The alignment assertion also assumes that cfg_base and every pointer stored in the table are multiples of 8. The bench memory model answers only accepted reads, with a pseudo-random delay of zero to three extra cycles. It also withdraws ready pseudo-randomly, so that the hold rule is exercised. All table contents are placed at 8-byte-aligned addresses. Chains are built from page numbers chosen to collide in the fold, so that walks of one, three and five reads occur in both layouts.

// File: rtl/cpt_pkg.sv
`timescale 1ns/1ps
package cpt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } walk_st_e;

    typedef enum logic [1:0] {
        PH_HEAD,
        PH_TAG,
        PH_DATA,
        PH_LINK
    } walk_ph_e;
endpackage

// File: rtl/cpt_fold_hash.sv
`timescale 1ns/1ps
module cpt_fold_hash #(
    parameter int TAG_W = 50,
    parameter int IDX_W = 8
) (
    input  logic [TAG_W-1:0] tag_hi,
    output logic [IDX_W-1:0] idx
);
    // Each tag bit folds onto index bit (position mod IDX_W).
    always_comb begin
        idx = '0;
        for (int i = 0; i < TAG_W; i++) begin
            idx[i % IDX_W] = idx[i % IDX_W] ^ tag_hi[i];
        end
    end
endmodule

// File: rtl/cpt_entry_decode.sv
`timescale 1ns/1ps
module cpt_entry_decode #(
    parameter int PPN_W   = 40,
    parameter bit PARTIAL = 1'b0
) (
    input  logic [63:0]      word,
    input  logic [1:0]       sel,
    output logic [PPN_W-1:0] frame,
    output logic             resident
);
    localparam int FRAME_LSB = 12;

    logic unused_word;
    assign unused_word = ^{word, sel};

    if (PARTIAL) begin : g_partial
        logic [3:0] map;
        assign map      = word[3:0];
        assign resident = map[sel];
        assign frame    = word[FRAME_LSB +: PPN_W] + PPN_W'(sel);
    end else begin : g_complete
        assign resident = 1'b1;
        assign frame    = word[PPN_W-1:0];
    end
endmodule

// File: rtl/cpt_walker.sv
`timescale 1ns/1ps
module cpt_walker #(
    parameter int VPN_W   = 52,
    parameter int PPN_W   = 40,
    parameter int IDX_W   = 8,
    parameter bit PARTIAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      cfg_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [63:0]      mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data
);
    import cpt_pkg::*;

    localparam int          TAG_W     = VPN_W - 2;
    localparam int          WORDS     = PARTIAL ? 3 : 6;
    localparam logic [63:0] LINK_OFF  = 64'((WORDS - 1) * 8);

    typedef struct packed {
        walk_st_e         st;
        walk_ph_e         ph;
        logic [VPN_W-1:0] vpn;
        logic [63:0]      addr;
        logic [63:0]      ent;
        logic             fault;
        logic [PPN_W-1:0] ppn;
    } walk_t;

    walk_t cur_q, nxt_d;

    logic [IDX_W-1:0] bucket_idx;
    logic [PPN_W-1:0] dec_frame;
    logic             dec_resident;
    logic [63:0]      data_off;
    logic             tag_hit;

    cpt_fold_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_hash (
        .tag_hi (req_vpn[VPN_W-1:2]),
        .idx    (bucket_idx)
    );

    cpt_entry_decode #(.PPN_W(PPN_W), .PARTIAL(PARTIAL)) u_dec (
        .word     (mem_rsp_data),
        .sel      (cur_q.vpn[1:0]),
        .frame    (dec_frame),
        .resident (dec_resident)
    );

    if (PARTIAL) begin : g_off_part
        assign data_off = 64'd8;
    end else begin : g_off_full
        assign data_off = 64'({1'b0, cur_q.vpn[1:0]} + 3'd1) << 3;
    end

    assign tag_hit = (mem_rsp_data[VPN_W-1:0] == {cur_q.vpn[VPN_W-1:2], 2'b00});

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.vpn  = req_vpn;
                    nxt_d.addr = cfg_base + 64'({bucket_idx, 3'b000});
                    nxt_d.ph   = PH_HEAD;
                    nxt_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) nxt_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (cur_q.ph)
                        PH_HEAD, PH_LINK: begin
                            if (mem_rsp_data == 64'd0) begin
                                nxt_d.st    = ST_RESP;
                                nxt_d.fault = 1'b1;
                                nxt_d.ppn   = '0;
                            end else begin
                                nxt_d.ent  = mem_rsp_data;
                                nxt_d.addr = mem_rsp_data;
                                nxt_d.ph   = PH_TAG;
                                nxt_d.st   = ST_ISSUE;
                            end
                        end
                        PH_TAG: begin
                            nxt_d.st = ST_ISSUE;
                            if (tag_hit) begin
                                nxt_d.ph   = PH_DATA;
                                nxt_d.addr = cur_q.ent + data_off;
                            end else begin
                                nxt_d.ph   = PH_LINK;
                                nxt_d.addr = cur_q.ent + LINK_OFF;
                            end
                        end
                        PH_DATA: begin
                            nxt_d.st    = ST_RESP;
                            nxt_d.fault = !dec_resident;
                            nxt_d.ppn   = dec_resident ? dec_frame : '0;
                        end
                        default: nxt_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_RESP: nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, ph: PH_HEAD, vpn: '0, addr: '0,
                       ent: '0, fault: 1'b0, ppn: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready     = (cur_q.st == ST_IDLE);
    assign mem_req_valid = (cur_q.st == ST_ISSUE);
    assign mem_req_addr  = cur_q.addr;
    assign rsp_valid     = (cur_q.st == ST_RESP);
    assign rsp_fault     = cur_q.fault;
    assign rsp_ppn       = cur_q.ppn;

    // R8: a stalled read keeps its address until taken
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R8: no new request while a read is awaiting data
    a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R9: response is one cycle wide
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: busy right after acceptance
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !rsp_valid);

    // R3: null bucket head yields a fault next cycle
    a_r3_null_head_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_WAIT) && (cur_q.ph == PH_HEAD) && mem_rsp_valid
            && (mem_rsp_data == 64'd0) |=> rsp_valid && rsp_fault && (rsp_ppn == '0));

    // R10: word-aligned reads
    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
endmodule

// File: tb/cpt_walker_tb.sv
`timescale 1ns/1ps
module cpt_mem_model #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_addr,
    output logic        rsp_valid,
    output logic [63:0] rsp_data,
    input  logic        clr,
    output int          reads,
    output logic [63:0] first_addr
);
    logic [63:0] mem [logic [63:0]];
    logic        pend;
    int          cnt;
    logic [63:0] raddr;
    logic [15:0] lf;
    logic        stall_q;
    logic [63:0] stall_addr;
    int          fails;

    task automatic wr(input logic [63:0] a, input logic [63:0] d);
        mem[a] = d;
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    initial fails = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            req_ready <= 1'b0;
            lf        <= SEED;
            stall_q   <= 1'b0;
            reads     <= 0;
            cnt       <= 0;
        end else begin
            lf        <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            req_ready <= lf[3] | lf[6];
            rsp_valid <= 1'b0;
            if (clr) reads <= 0;
            if (stall_q && (!req_valid || req_addr != stall_addr)) begin
                fails = fails + 1;
                $display("FAIL R8: request dropped or address moved while stalled, act %h exp %h",
                         req_addr, stall_addr);
            end
            stall_q    <= req_valid && !req_ready;
            stall_addr <= req_addr;
            if (pend) begin
                if (cnt == 0) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= rd(raddr);
                    pend      <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
            if (req_valid && req_ready) begin
                if (pend) begin
                    fails = fails + 1;
                    $display("FAIL R8: second read while one outstanding, act 1 exp 0");
                end
                if (req_addr[2:0] != 3'b000) begin
                    fails = fails + 1;
                    $display("FAIL R10: unaligned address, act %h exp low bits 0", req_addr);
                end
                if (reads == 0 || clr) first_addr <= req_addr;
                reads <= (clr ? 0 : reads) + 1;
                pend  <= 1'b1;
                raddr <= req_addr;
                cnt   <= int'(lf[1:0]);
            end
        end
    end
endmodule

module cpt_walker_tb;
    localparam int VPN_W = 52;
    localparam int PPN_W = 40;
    localparam int IDX_W = 8;
    localparam logic [63:0] BASE_C = 64'h1000_0000;
    localparam logic [63:0] BASE_P = 64'h3000_0000;

    typedef struct {
        string            req;
        logic             fault;
        logic [PPN_W-1:0] ppn;
        int               reads;
        logic [63:0]      head;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    item_t q0[$];
    item_t q1[$];

    // complete-mode port
    logic             rv_c = 0, rr_c, sv_c, sf_c, mv_c, mr_c, mrv_c, clr_c = 0;
    logic [VPN_W-1:0] vpn_c = '0;
    logic [PPN_W-1:0] ppn_c;
    logic [63:0]      ma_c, md_c, fa_c;
    int               rd_c;
    // partial-mode port
    logic             rv_p = 0, rr_p, sv_p, sf_p, mv_p, mr_p, mrv_p, clr_p = 0;
    logic [VPN_W-1:0] vpn_p = '0;
    logic [PPN_W-1:0] ppn_p;
    logic [63:0]      ma_p, md_p, fa_p;
    int               rd_p;

    cpt_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .PARTIAL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE_C),
        .req_valid(rv_c), .req_ready(rr_c), .req_vpn(vpn_c),
        .rsp_valid(sv_c), .rsp_fault(sf_c), .rsp_ppn(ppn_c),
        .mem_req_valid(mv_c), .mem_req_ready(mr_c), .mem_req_addr(ma_c),
        .mem_rsp_valid(mrv_c), .mem_rsp_data(md_c)
    );
    cpt_mem_model #(.SEED(16'hACE1)) u_mem_c (
        .clk(clk), .rst_n(rst_n), .req_valid(mv_c), .req_ready(mr_c), .req_addr(ma_c),
        .rsp_valid(mrv_c), .rsp_data(md_c), .clr(clr_c), .reads(rd_c), .first_addr(fa_c)
    );

    cpt_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .PARTIAL(1'b1)) u_dut_part (
        .clk(clk), .rst_n(rst_n), .cfg_base(BASE_P),
        .req_valid(rv_p), .req_ready(rr_p), .req_vpn(vpn_p),
        .rsp_valid(sv_p), .rsp_fault(sf_p), .rsp_ppn(ppn_p),
        .mem_req_valid(mv_p), .mem_req_ready(mr_p), .mem_req_addr(ma_p),
        .mem_rsp_valid(mrv_p), .mem_rsp_data(md_p)
    );
    cpt_mem_model #(.SEED(16'h5A3C)) u_mem_p (
        .clk(clk), .rst_n(rst_n), .req_valid(mv_p), .req_ready(mr_p), .req_addr(ma_p),
        .rsp_valid(mrv_p), .rsp_data(md_p), .clr(clr_p), .reads(rd_p), .first_addr(fa_p)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s act %h exp %h", req, what, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] fold(input logic [VPN_W-1:0] v);
        logic [IDX_W-1:0] h = '0;
        for (int i = 2; i < VPN_W; i++) h[(i-2) % IDX_W] ^= v[i];
        return h;
    endfunction

    function automatic logic [63:0] head_of(input logic [63:0] base, input logic [VPN_W-1:0] v);
        return base + 64'(fold(v)) * 64'd8;
    endfunction

    // Scoreboard monitor
    task automatic score(input item_t it, input logic f, input logic [PPN_W-1:0] p,
                         input int n, input logic [63:0] h);
        chk(it.req, "fault", 64'(f), 64'(it.fault));
        chk(it.req, "ppn", 64'(p), 64'(it.ppn));
        chk(it.req, "read count", 64'(n), 64'(it.reads));
        chk("R2", "bucket address", h, it.head);
    endtask

    always @(negedge clk) begin
        if (rst_n && sv_c) begin
            if (q0.size() == 0) chk("R9", "unexpected response (complete)", 64'd1, 64'd0);
            else score(q0.pop_front(), sf_c, ppn_c, rd_c, fa_c);
        end
        if (rst_n && sv_p) begin
            if (q1.size() == 0) chk("R9", "unexpected response (partial)", 64'd1, 64'd0);
            else score(q1.pop_front(), sf_p, ppn_p, rd_p, fa_p);
        end
    end

    // Driver: pushes expectation then issues the request
    task automatic send(input bit part, input logic [VPN_W-1:0] v, input string req,
                        input logic f, input logic [PPN_W-1:0] p, input int n);
        item_t it;
        it.req = req; it.fault = f; it.ppn = p; it.reads = n;
        it.head = head_of(part ? BASE_P : BASE_C, v);
        @(negedge clk);
        if (!part) begin
            while (!rr_c) @(negedge clk);
            q0.push_back(it);
            rv_c = 1; vpn_c = v; clr_c = 1;
            @(negedge clk);
            rv_c = 0; clr_c = 0;
            chk("R9", "req_ready after accept", 64'(rr_c), 64'd0);
            while (q0.size() != 0) @(negedge clk);
        end else begin
            while (!rr_p) @(negedge clk);
            q1.push_back(it);
            rv_p = 1; vpn_p = v; clr_p = 1;
            @(negedge clk);
            rv_p = 0; clr_p = 0;
            chk("R9", "req_ready after accept", 64'(rr_p), 64'd0);
            while (q1.size() != 0) @(negedge clk);
        end
    endtask

    localparam logic [VPN_W-1:0] VA = 52'h0_1234_5678_9AB0;
    localparam logic [VPN_W-1:0] VB = VA ^ 52'h404;  // same bucket as VA
    localparam logic [VPN_W-1:0] VC = VA ^ 52'h808;  // same bucket, absent
    localparam logic [VPN_W-1:0] VE = VA ^ 52'h004;  // different, empty bucket

    initial begin
        // Complete-mode table: bucket -> EB -> EA
        u_mem_c.wr(head_of(BASE_C, VA), 64'h2000_0200);
        u_mem_c.wr(64'h2000_0200, {12'hABC, VB});
        for (int k = 0; k < 4; k++)
            u_mem_c.wr(64'h2000_0208 + 64'(8*k), {24'hFFFFFF, 40'hB_0000_0000 + 40'(k)});
        u_mem_c.wr(64'h2000_0228, 64'h2000_0100);
        u_mem_c.wr(64'h2000_0100, {12'h000, VA});
        for (int k = 0; k < 4; k++)
            u_mem_c.wr(64'h2000_0108 + 64'(8*k), {24'hEEEEEE, 40'hA_0000_0001 + 40'(k)});
        u_mem_c.wr(64'h2000_0128, 64'd0);
        // Partial-mode table: bucket -> FB -> FA
        u_mem_p.wr(head_of(BASE_P, VA), 64'h4000_0200);
        u_mem_p.wr(64'h4000_0200, {12'h000, VB});
        u_mem_p.wr(64'h4000_0208, (64'(40'h8_0000_0010) << 12) | 64'h0F4);
        u_mem_p.wr(64'h4000_0210, 64'h4000_0100);
        u_mem_p.wr(64'h4000_0100, {12'h000, VA});
        u_mem_p.wr(64'h4000_0108, (64'(40'h7_0000_0000) << 12) | 64'h0AB);
        u_mem_p.wr(64'h4000_0110, 64'd0);

        repeat (3) @(negedge clk);
        chk("R1", "req_ready in reset", 64'(rr_c), 64'd1);
        chk("R1", "rsp_valid in reset", 64'(sv_c), 64'd0);
        chk("R1", "mem_req_valid in reset", 64'(mv_p), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "req_ready after reset", 64'(rr_p), 64'd1);
        chk("R1", "mem_req_valid after reset", 64'(mv_c), 64'd0);

        // complete mode
        send(0, VE,      "R3", 1'b1, '0, 1);
        send(0, VB,      "R6", 1'b0, 40'hB_0000_0000, 3);
        send(0, VB | 2,  "R6", 1'b0, 40'hB_0000_0002, 3);
        send(0, VA | 3,  "R4", 1'b0, 40'hA_0000_0004, 5);
        send(0, VA | 1,  "R4", 1'b0, 40'hA_0000_0002, 5);
        send(0, VC,      "R5", 1'b1, '0, 5);
        // partial mode
        send(1, VE,      "R3", 1'b1, '0, 1);
        send(1, VB | 2,  "R7", 1'b0, 40'h8_0000_0012, 3);
        send(1, VB,      "R7", 1'b1, '0, 3);
        send(1, VA,      "R7", 1'b0, 40'h7_0000_0000, 5);
        send(1, VA | 1,  "R7", 1'b0, 40'h7_0000_0001, 5);
        send(1, VA | 2,  "R7", 1'b1, '0, 5);
        send(1, VA | 3,  "R4", 1'b0, 40'h7_0000_0003, 5);
        send(1, VC | 1,  "R5", 1'b1, '0, 5);

        repeat (5) @(negedge clk);
        checks += 2;
        errors += u_mem_c.fails + u_mem_p.fails;  // R8 / R10 protocol monitors
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule